// File: doc/BRIEF.md
# Boot Command Responder

This block sits behind a CAN receive path on a controller that is in boot mode. A host tool sends short command frames to put two processors through erase, block-count setup, block upload and checksum phases, and to set transfer addresses. Each frame arrives as one cycle of `rx_valid` with an 11-bit identifier, a byte count and eight payload bytes. The block decodes the frame and builds one seven-byte acknowledge frame for each command it accepts.

Each command that changes state raises a single-cycle event toward the rest of the boot logic. An accepted erase/reflash request raises an event that names the processor, the phase and an optional 16-bit checksum. An accepted address command raises an event that carries the 24-bit address. Validate queries read a 2-bit completion code for the addressed processor and phase from an external status vector, and return it as a three-byte tail. The response waits in a one-entry slot with a valid/ready handshake.

Top module: `boot_cmd_responder`

## Requirements
- R1: Only frames with identifier 0x020 are acted on. Every response has identifier 0x030 and a length of 7.
- R2: Byte k of a payload sits at bits [8k+7:8k]. A frame is considered only if `rx_len` is between 2 and 8 and byte 0 equals `rx_len`-1. Byte 1 is the command code and byte 2 is the option. Every response begins 0x06, 0x7F, then the command code, and its byte 7 is 0x00.
- R3: Command 0x20 or 0x3F (ping) returns 06 7F cmd 00 00 00 00.
- R4: A sub-target byte is valid only when its high nibble is 0xA (processor 0) or 0xB (processor 1) and its low nibble is 0 to 3. The low nibble is the phase: 0 block-count, 1 erase, 2 upload, 3 checksum. Commands 0x31 and 0x32 with any other sub-target get no response.
- R5: Command 0x31 with a valid sub-target returns 06 7F 31 sub 00 00 00. In the next cycle `req_pulse` is high for one cycle, with `req_cpu` and `req_phase` decoded from the sub-target.
- R6: For a checksum-phase 0x31, payload bytes 3 and 4 are echoed in response bytes 4 and 5 and appear on `req_arg` as {byte3, byte4}. Other phases give `req_arg` = 0.
- R7: Command 0x32 returns 06 7F 32 sub and then a tail chosen by the 2-bit code at `proc_status[2i+1:2i]`, where i = cpu*4+phase. The tails are: 0 success 00 00 00, 1 fail 00 58 63, 2 ongoing 00 00 21, 3 error 00 4A 63.
- R8: Command 0x34 (upload address) or 0x35 (download) with option 0x00 or 0x80 returns 06 7F cmd opt 04 00 byte5. It pulses `addr_pulse` with `addr_dl` = 1 for 0x35, `addr_mode` = 1 for option 0x80, and `addr_value` = {byte5, byte6, byte7}. Any other option gets no response.
- R9: Command 0x37 with option 0x00 or 0x80 returns 06 7F 37 opt 00 00 00.
- R10: Command 0x22 returns 06 7F 22 byte2 byte3 followed by `info_word` high byte then low byte.
- R11: A frame with any other command code produces no response and no event.
- R12: A response becomes valid in the cycle after its frame. It holds with stable data until `tx_ready`. A command that arrives while `tx_valid` is high and `tx_ready` is low is dropped with no response and no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received frame present this cycle |
| rx_id | input | 11 | Frame identifier |
| rx_len | input | 4 | Payload byte count |
| rx_data | input | 64 | Payload, byte k at [8k+7:8k] |
| proc_status | input | 16 | 2-bit phase completion codes, entry cpu*4+phase |
| info_word | input | 16 | Value returned by the 0x22 read |
| tx_valid | output | 1 | Response slot full |
| tx_ready | input | 1 | Consumer takes the response |
| tx_id | output | 11 | Response identifier |
| tx_len | output | 4 | Response byte count |
| tx_data | output | 64 | Response payload |
| req_pulse | output | 1 | Erase/reflash request accepted |
| req_cpu | output | 1 | Processor of the request |
| req_phase | output | 2 | Phase of the request |
| req_arg | output | 16 | Expected checksum for checksum phase |
| addr_pulse | output | 1 | Address command accepted |
| addr_dl | output | 1 | 1 for download, 0 for upload address |
| addr_mode | output | 1 | 1 when option was 0x80 |
| addr_value | output | 24 | Address from payload bytes 5..7 |

## Verification
The assertions check the following on every cycle. The response identifier, length and header stay fixed. A stalled response does not move. A frame with a foreign identifier or an unknown command, arriving while the slot is empty, produces nothing. Each request or address event coincides with a response of the matching command. Only the bench scenarios can show that the bytes are right: the checksum echo, the four validate tails picked from the right status entry, the address and mode fields, and the rejection of bad sub-targets, bad options and inconsistent lengths. The same holds for the drop rule, where a command is lost while a response waits.

// File: rtl/boot_resp_pkg.sv
package boot_resp_pkg;

   localparam logic [7:0] RSP_B0 = 8'h06;
   localparam logic [7:0] RSP_B1 = 8'h7F;

   typedef enum logic [7:0] {
      OP_PING_LO = 8'h20,
      OP_READ    = 8'h22,
      OP_REQUEST = 8'h31,
      OP_CHECK   = 8'h32,
      OP_UP_ADDR = 8'h34,
      OP_DN_ADDR = 8'h35,
      OP_FINISH  = 8'h37,
      OP_PING_HI = 8'h3F
   } op_e;

   typedef enum logic [1:0] {
      PH_OK   = 2'd0,
      PH_FAIL = 2'd1,
      PH_BUSY = 2'd2,
      PH_ERR  = 2'd3
   } phase_st_e;

   // tail bytes 4,5,6 packed with byte 4 in the low bits
   function automatic logic [23:0] tail_of(phase_st_e s);
      case (s)
         PH_FAIL: tail_of = 24'h635800;
         PH_BUSY: tail_of = 24'h210000;
         PH_ERR:  tail_of = 24'h634A00;
         default: tail_of = 24'h000000;
      endcase
   endfunction

endpackage

// File: rtl/boot_status_sel.sv
module boot_status_sel #(
   parameter int NUM_CPU       = 2,
   parameter int NUM_PHASE     = 4,
   parameter int CPU_W         = 1,
   parameter bit SAMPLE_STATUS = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [2*NUM_CPU*NUM_PHASE-1:0] status_in,
   input  logic [CPU_W-1:0]               cpu,
   input  logic [1:0]                     phase,
   output boot_resp_pkg::phase_st_e       code
);
   localparam int ENTRIES = NUM_CPU * NUM_PHASE;

   logic [2*ENTRIES-1:0] src;
   logic [1:0]           tbl [ENTRIES];

   generate
      if (SAMPLE_STATUS) begin : g_sampled
         always_ff @(posedge clk) begin
            if (!rst_n) src <= '0;
            else        src <= status_in;
         end
      end else begin : g_direct
         assign src = status_in;
      end
      for (genvar e = 0; e < ENTRIES; e++) begin : g_tbl
         assign tbl[e] = src[2*e +: 2];
      end
   endgenerate

   always_comb begin
      int idx;
      idx  = int'(cpu) * NUM_PHASE + int'(phase);
      code = boot_resp_pkg::PH_OK;
      if (idx < ENTRIES) code = boot_resp_pkg::phase_st_e'(tbl[idx]);
   end
endmodule

// File: rtl/boot_cmd_decode.sv
module boot_cmd_decode #(
   parameter logic [10:0] CMD_ID       = 11'h020,
   parameter int          NUM_CPU      = 2,
   parameter logic [3:0]  CPU_NIB_BASE = 4'hA,
   parameter int          CPU_W        = 1,
   parameter int          CSUM_PHASE   = 3
) (
   input  logic [10:0]               rx_id,
   input  logic [3:0]                rx_len,
   input  logic [63:0]               rx_data,
   input  logic [15:0]               info_word,
   input  boot_resp_pkg::phase_st_e  st_code,
   output logic                      hit,
   output logic [63:0]               rsp,
   output logic                      is_req,
   output logic                      is_addr,
   output logic [CPU_W-1:0]          cpu,
   output logic [1:0]                phase,
   output logic [15:0]               arg
);
   import boot_resp_pkg::*;

   logic [7:0] b [8];
   logic [7:0] r [8];
   logic [4:0] cpu_off;
   logic       sub_ok, opt_ok, frame_ok;
   logic [7:0] op, opt;

   always_comb begin
      for (int k = 0; k < 8; k++) b[k] = rx_data[8*k +: 8];
      op  = b[1];
      opt = b[2];
      cpu_off  = {1'b0, opt[7:4]} - {1'b0, CPU_NIB_BASE};
      sub_ok   = (opt[7:4] >= CPU_NIB_BASE) && (cpu_off < 5'(NUM_CPU)) && (opt[3:2] == 2'b00);
      cpu      = cpu_off[CPU_W-1:0];
      phase    = opt[1:0];
      opt_ok   = (opt == 8'h00) || (opt == 8'h80);
      frame_ok = (rx_id == CMD_ID) && (rx_len >= 4'd2) && (rx_len <= 4'd8)
                 && (b[0] == ({4'd0, rx_len} - 8'd1));

      for (int k = 0; k < 8; k++) r[k] = 8'h00;
      r[0]    = RSP_B0;
      r[1]    = RSP_B1;
      r[2]    = op;
      hit     = 1'b0;
      is_req  = 1'b0;
      is_addr = 1'b0;
      arg     = 16'h0000;

      case (op)
         OP_PING_LO, OP_PING_HI: hit = 1'b1;
         OP_READ: begin
            hit  = 1'b1;
            r[3] = b[2];
            r[4] = b[3];
            r[5] = info_word[15:8];
            r[6] = info_word[7:0];
         end
         OP_REQUEST: begin
            hit    = sub_ok;
            is_req = sub_ok;
            r[3]   = opt;
            if (int'(phase) == CSUM_PHASE) begin
               r[4] = b[3];
               r[5] = b[4];
               arg  = {b[3], b[4]};
            end
         end
         OP_CHECK: begin
            hit  = sub_ok;
            r[3] = opt;
            {r[6], r[5], r[4]} = tail_of(st_code);
         end
         OP_UP_ADDR, OP_DN_ADDR: begin
            hit     = opt_ok;
            is_addr = opt_ok;
            r[3]    = opt;
            r[4]    = 8'h04;
            r[6]    = b[5];
         end
         OP_FINISH: begin
            hit  = opt_ok;
            r[3] = opt;
         end
         default: hit = 1'b0;
      endcase

      hit = hit & frame_ok;
      for (int k = 0; k < 8; k++) rsp[8*k +: 8] = r[k];
   end
endmodule

// File: rtl/boot_tx_slot.sv
module boot_tx_slot #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   output logic              space,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   assign space = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (push) begin
         out_valid <= 1'b1;
         out_data  <= push_data;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/boot_cmd_responder.sv
module boot_cmd_responder #(
   parameter logic [10:0] CMD_ID        = 11'h020,
   parameter logic [10:0] RSP_ID        = 11'h030,
   parameter int          NUM_CPU       = 2,
   parameter logic [3:0]  CPU_NIB_BASE  = 4'hA,
   parameter bit          SAMPLE_STATUS = 1'b0,
   localparam int         NUM_PHASE     = 4,
   localparam int         CPU_W         = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   localparam int         ST_W          = 2 * NUM_CPU * NUM_PHASE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic [10:0]      rx_id,
   input  logic [3:0]       rx_len,
   input  logic [63:0]      rx_data,
   input  logic [ST_W-1:0]  proc_status,
   input  logic [15:0]      info_word,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [10:0]      tx_id,
   output logic [3:0]       tx_len,
   output logic [63:0]      tx_data,
   output logic             req_pulse,
   output logic [CPU_W-1:0] req_cpu,
   output logic [1:0]       req_phase,
   output logic [15:0]      req_arg,
   output logic             addr_pulse,
   output logic             addr_dl,
   output logic             addr_mode,
   output logic [23:0]      addr_value
);
   localparam int CSUM_PHASE = 3;
   localparam int RSP_BYTES  = 7;

   generate
      if (NUM_CPU < 1 || int'(CPU_NIB_BASE) + NUM_CPU > 16) begin : g_bad_cpu
         $error("boot_cmd_responder: NUM_CPU does not fit the sub-target nibble");
      end
      if (CMD_ID == RSP_ID) begin : g_bad_id
         $error("boot_cmd_responder: command and response identifiers collide");
      end
   endgenerate

   boot_resp_pkg::phase_st_e st_code;
   logic             hit, is_req, is_addr, space, accept;
   logic [63:0]      rsp;
   logic [CPU_W-1:0] dcpu;
   logic [1:0]       dphase;
   logic [15:0]      darg;

   boot_cmd_decode #(
      .CMD_ID(CMD_ID), .NUM_CPU(NUM_CPU), .CPU_NIB_BASE(CPU_NIB_BASE),
      .CPU_W(CPU_W), .CSUM_PHASE(CSUM_PHASE)
   ) u_dec (
      .rx_id(rx_id), .rx_len(rx_len), .rx_data(rx_data), .info_word(info_word),
      .st_code(st_code), .hit(hit), .rsp(rsp), .is_req(is_req), .is_addr(is_addr),
      .cpu(dcpu), .phase(dphase), .arg(darg)
   );

   boot_status_sel #(
      .NUM_CPU(NUM_CPU), .NUM_PHASE(NUM_PHASE), .CPU_W(CPU_W), .SAMPLE_STATUS(SAMPLE_STATUS)
   ) u_st (
      .clk(clk), .rst_n(rst_n), .status_in(proc_status), .cpu(dcpu), .phase(dphase),
      .code(st_code)
   );

   assign accept = rx_valid && hit && space;

   boot_tx_slot #(.DATA_W(64)) u_slot (
      .clk(clk), .rst_n(rst_n), .push(accept), .push_data(rsp), .space(space),
      .out_valid(tx_valid), .out_ready(tx_ready), .out_data(tx_data)
   );

   assign tx_id  = RSP_ID;
   assign tx_len = 4'(RSP_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_pulse  <= 1'b0;
         req_cpu    <= '0;
         req_phase  <= '0;
         req_arg    <= '0;
         addr_pulse <= 1'b0;
         addr_dl    <= 1'b0;
         addr_mode  <= 1'b0;
         addr_value <= '0;
      end else begin
         req_pulse  <= accept && is_req;
         addr_pulse <= accept && is_addr;
         if (accept && is_req) begin
            req_cpu   <= dcpu;
            req_phase <= dphase;
            req_arg   <= darg;
         end
         if (accept && is_addr) begin
            addr_dl    <= rx_data[8] ;
            addr_mode  <= rx_data[23];
            addr_value <= {rx_data[47:40], rx_data[55:48], rx_data[63:56]};
         end
      end
   end
endmodule

// File: rtl/boot_cmd_responder_chk.sv
module boot_cmd_responder_chk #(
   parameter logic [10:0] CMD_ID = 11'h020,
   parameter logic [10:0] RSP_ID = 11'h030
) (
   input logic        clk,
   input logic        rst_n,
   input logic        rx_valid,
   input logic [10:0] rx_id,
   input logic [63:0] rx_data,
   input logic        tx_valid,
   input logic        tx_ready,
   input logic [10:0] tx_id,
   input logic [3:0]  tx_len,
   input logic [63:0] tx_data,
   input logic        req_pulse,
   input logic        addr_pulse
);
   logic [7:0] op;
   logic       op_known;
   assign op = rx_data[15:8];
   assign op_known = (op == 8'h20) || (op == 8'h3F) || (op == 8'h22) || (op == 8'h31) ||
                     (op == 8'h32) || (op == 8'h34) || (op == 8'h35) || (op == 8'h37);

   AST_RSP_ID_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_id == RSP_ID && tx_len == 4'd7)); // R1
   AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_id != CMD_ID && !tx_valid) |=> !tx_valid); // R1
   AST_RSP_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_data[15:0] == 16'h7F06 && tx_data[63:56] == 8'h00)); // R2
   AST_REQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      req_pulse |-> (tx_valid && tx_data[23:16] == 8'h31)); // R5
   AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      addr_pulse |-> (tx_valid && (tx_data[23:16] == 8'h34 || tx_data[23:16] == 8'h35))); // R8
   AST_UNKNOWN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !op_known && !tx_valid) |=> !tx_valid); // R11
   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R12
   AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (!req_pulse && !addr_pulse)); // R12
endmodule

bind boot_cmd_responder boot_cmd_responder_chk #(.CMD_ID(CMD_ID), .RSP_ID(RSP_ID)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id), .rx_data(rx_data),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_id(tx_id), .tx_len(tx_len),
   .tx_data(tx_data), .req_pulse(req_pulse), .addr_pulse(addr_pulse)
);

// File: tb/sim_boot_cmd_responder.sv
`timescale 1ns/1ps
module sim_boot_cmd_responder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [10:0] rx_id = '0;
   logic [3:0]  rx_len = '0;
   logic [63:0] rx_data = '0;
   logic [15:0] proc_status = 16'hE004;
   logic [15:0] info_word = 16'hBEEF;
   logic        tx_ready = 1'b1;
   logic        tx_valid;
   logic [10:0] tx_id;
   logic [3:0]  tx_len;
   logic [63:0] tx_data;
   logic        req_pulse, req_cpu, addr_pulse, addr_dl, addr_mode;
   logic [1:0]  req_phase;
   logic [15:0] req_arg;
   logic [23:0] addr_value;

   int n_checks = 0;
   int n_fail = 0;
   bit reported = 0;
   logic [63:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   boot_cmd_responder u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id), .rx_len(rx_len),
      .rx_data(rx_data), .proc_status(proc_status), .info_word(info_word),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_id(tx_id), .tx_len(tx_len),
      .tx_data(tx_data), .req_pulse(req_pulse), .req_cpu(req_cpu), .req_phase(req_phase),
      .req_arg(req_arg), .addr_pulse(addr_pulse), .addr_dl(addr_dl), .addr_mode(addr_mode),
      .addr_value(addr_value)
   );

   function automatic logic [63:0] mk(input logic [7:0] a0, a1, a2, a3, a4, a5, a6, a7);
      return {a7, a6, a5, a4, a3, a2, a1, a0};
   endfunction

   function automatic logic [63:0] rsp(input logic [7:0] c, d, e, f, g);
      return mk(8'h06, 8'h7F, c, d, e, f, g, 8'h00);
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   // monitor: pops the scoreboard whenever a response is handed over
   always @(negedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         if (exp_q.size() == 0) begin
            check("R11 unexpected response", tx_data, 64'h0);
            if (tx_data == 64'h0) begin
               n_fail++;
               $display("FAIL R11 unexpected response actual=%h expected=none", tx_data);
            end
         end else begin
            string t;
            logic [63:0] e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, tx_data, e);
            check({t, " id/len (R1)"}, {53'h0, tx_id, tx_len}, {53'h0, 11'h030, 4'd7});
         end
      end
   end

   // driver: pushes the expected response, then drives the frame for one cycle
   task automatic send(input logic [10:0] id, input logic [3:0] len, input logic [63:0] d,
                       input bit expect_rsp, input logic [63:0] exp, input string tag);
      @(negedge clk);
      if (expect_rsp) begin
         exp_q.push_back(exp);
         tag_q.push_back(tag);
      end
      rx_valid = 1'b1;
      rx_id    = id;
      rx_len   = len;
      rx_data  = d;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic quiet(input string tag);
      check({tag, " no output"}, {61'h0, tx_valid, req_pulse, addr_pulse}, 64'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R12 reset state", {61'h0, tx_valid, req_pulse, addr_pulse}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 pings
      send(11'h020, 4'd2, mk(8'h01, 8'h20, 0, 0, 0, 0, 0, 0), 1, rsp(8'h20, 0, 0, 0, 0), "R3 ping 0x20");
      send(11'h020, 4'd2, mk(8'h01, 8'h3F, 0, 0, 0, 0, 0, 0), 1, rsp(8'h3F, 0, 0, 0, 0), "R3 ping 0x3F");
      // R10 read
      send(11'h020, 4'd4, mk(8'h03, 8'h22, 8'hE7, 8'h29, 0, 0, 0, 0), 1,
           rsp(8'h22, 8'hE7, 8'h29, 8'hBE, 8'hEF), "R10 read");
      // R5 erase request
      send(11'h020, 4'd7, mk(8'h06, 8'h31, 8'hA1, 0, 0, 0, 0, 0), 1,
           rsp(8'h31, 8'hA1, 0, 0, 0), "R5 request A1");
      check("R5 req event A1", {44'h0, req_pulse, req_cpu, req_phase, req_arg},
            {44'h0, 1'b1, 1'b0, 2'd1, 16'h0000});
      // R6 checksum request on processor 1
      send(11'h020, 4'd5, mk(8'h04, 8'h31, 8'hB3, 8'h12, 8'h34, 0, 0, 0), 1,
           rsp(8'h31, 8'hB3, 8'h12, 8'h34, 0), "R6 checksum echo");
      check("R6 req event B3", {44'h0, req_pulse, req_cpu, req_phase, req_arg},
            {44'h0, 1'b1, 1'b1, 2'd3, 16'h1234});
      // R7 validate tails; proc_status = E004
      send(11'h020, 4'd3, mk(8'h02, 8'h32, 8'hA0, 0, 0, 0, 0, 0), 1, rsp(8'h32, 8'hA0, 0, 0, 0), "R7 success");
      send(11'h020, 4'd3, mk(8'h02, 8'h32, 8'hA1, 0, 0, 0, 0, 0), 1, rsp(8'h32, 8'hA1, 0, 8'h58, 8'h63), "R7 fail");
      send(11'h020, 4'd3, mk(8'h02, 8'h32, 8'hB2, 0, 0, 0, 0, 0), 1, rsp(8'h32, 8'hB2, 0, 0, 8'h21), "R7 ongoing");
      send(11'h020, 4'd3, mk(8'h02, 8'h32, 8'hB3, 0, 0, 0, 0, 0), 1, rsp(8'h32, 8'hB3, 0, 8'h4A, 8'h63), "R7 error");
      // R8 address commands
      send(11'h020, 4'd8, mk(8'h07, 8'h34, 8'h80, 8'h04, 8'h00, 8'h01, 8'h02, 8'h03), 1,
           rsp(8'h34, 8'h80, 8'h04, 8'h00, 8'h01), "R8 upload address");
      check("R8 addr event 0x34", {36'h0, addr_pulse, addr_dl, addr_mode, addr_value},
            {36'h0, 1'b1, 1'b0, 1'b1, 24'h010203});
      send(11'h020, 4'd8, mk(8'h07, 8'h35, 8'h00, 8'h04, 8'h00, 8'h9A, 8'hBC, 8'hDE), 1,
           rsp(8'h35, 8'h00, 8'h04, 8'h00, 8'h9A), "R8 download address");
      check("R8 addr event 0x35", {36'h0, addr_pulse, addr_dl, addr_mode, addr_value},
            {36'h0, 1'b1, 1'b1, 1'b0, 24'h9ABCDE});
      // R9 finalize
      send(11'h020, 4'd3, mk(8'h02, 8'h37, 8'h80, 0, 0, 0, 0, 0), 1, rsp(8'h37, 8'h80, 0, 0, 0), "R9 finalize");

      // ignored frames
      send(11'h021, 4'd2, mk(8'h01, 8'h20, 0, 0, 0, 0, 0, 0), 0, 0, "");
      quiet("R1 foreign id");
      send(11'h020, 4'd8, mk(8'h07, 8'h36, 1, 2, 3, 4, 5, 6), 0, 0, "");
      quiet("R11 unknown code");
      send(11'h020, 4'd3, mk(8'h02, 8'h32, 8'hC1, 0, 0, 0, 0, 0), 0, 0, "");
      quiet("R4 bad cpu nibble");
      send(11'h020, 4'd7, mk(8'h06, 8'h31, 8'hA4, 0, 0, 0, 0, 0), 0, 0, "");
      quiet("R4 bad phase nibble");
      send(11'h020, 4'd8, mk(8'h07, 8'h34, 8'h40, 8'h04, 0, 1, 2, 3), 0, 0, "");
      quiet("R8 bad option");
      send(11'h020, 4'd3, mk(8'h05, 8'h32, 8'hA0, 0, 0, 0, 0, 0), 0, 0, "");
      quiet("R2 length mismatch");

      // R12 stall and drop
      tx_ready = 1'b0;
      send(11'h020, 4'd2, mk(8'h01, 8'h20, 0, 0, 0, 0, 0, 0), 1, rsp(8'h20, 0, 0, 0, 0), "R12 held ping");
      send(11'h020, 4'd7, mk(8'h06, 8'h31, 8'hB1, 0, 0, 0, 0, 0), 0, 0, "");
      check("R12 dropped request", {62'h0, req_pulse, tx_valid}, {62'h0, 1'b0, 1'b1});
      check("R12 held data", tx_data, rsp(8'h20, 0, 0, 0, 0));
      repeat (2) @(negedge clk);
      check("R12 still held", {63'h0, tx_valid}, 64'h1);
      tx_ready = 1'b1;
      repeat (3) @(negedge clk);
      check("R12 scoreboard drained", 64'(exp_q.size()), 64'h0);
      report();
   end
endmodule